// File: doc/BRIEF.md
# DDS Output Reset Controller

This block produces the internal reset for a direct digital synthesis datapath and gates the code that the datapath hands to its converter. The reset can come from an external pin or from a bit held in the control register. A select input decides which of the two is in charge, and the source that is not selected has no effect.

Reset takes hold at once, without waiting for a clock edge. The datapath is held cleared and the converter code is forced to midscale. Release is sampled only on a falling edge of the master clock. After that edge a restart timer counts a fixed number of further falling edges, seven by default, before the output is marked valid. Only then does the datapath code pass through. If reset returns during the count, the count is dropped and starts again from zero on the next release. The tuning, phase and control registers are outside this block, and this reset does not touch them.

Top module: `dds_reset_ctrl`

## Requirements
- R1: When `pin_sel_i` is 1, `rst_pin_i` alone decides reset: a high pin asserts `dp_rst_o`, and `rst_bit_i` has no effect on `dp_rst_o`, `out_valid_o` or `dac_code_o`.
- R2: When `pin_sel_i` is 0, `rst_bit_i` alone decides reset: a high bit asserts `dp_rst_o`, and `rst_pin_i` has no effect on `dp_rst_o`, `out_valid_o` or `dac_code_o`.
- R3: When the selected source goes high, `dp_rst_o` goes high, `out_valid_o` goes low and `dac_code_o` goes to midscale within the same clock phase, without any clock edge.
- R4: After the selected source goes low, `dp_rst_o` stays high until the next falling edge of `clk_i` and drops on that edge.
- R5: `out_valid_o` stays low through the first six falling edges after the release edge and goes high on the seventh (LATENCY = 7).
- R6: While `out_valid_o` is low, `dac_code_o` is midscale: the MSB is 1 and all other bits are 0 (10'h200 for CODE_W = 10), whatever `dp_code_i` holds.
- R7: While `out_valid_o` is high, `dac_code_o` equals `dp_code_i` and follows it without delay.
- R8: If the selected source rises again before `out_valid_o` has gone high, the count is discarded, and after the next release the full seven-edge delay applies again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock; its falling edge samples release |
| rst_pin_i | input | 1 | External reset pin, active high |
| rst_bit_i | input | 1 | Reset bit from the control register, active high |
| pin_sel_i | input | 1 | Source select: 1 selects the pin, 0 selects the register bit |
| dp_code_i | input | CODE_W | Code produced by the synthesis datapath |
| dp_rst_o | output | 1 | Reset that clears the datapath registers |
| out_valid_o | output | 1 | High once the restart delay has expired |
| dac_code_o | output | CODE_W | Code sent to the converter, midscale while not valid |

## Verification
Each select setting is run twice: once with the selected source toggled and once with only the other source toggled. This separates correct source selection from a plain OR of the two sources. Reset is raised halfway through a clock phase and checked before the next edge, so an asynchronous set can be told apart from a sampled one. The release is counted edge by edge, which catches a count that is one cycle short or one cycle long. Reset is also raised again partway through a count, which shows whether the timer restarts from zero or resumes. With the output valid, the datapath code is driven with all-ones, all-zeros and alternating bits, so a code that passes through can be told apart from one stuck at midscale.

// File: rtl/dds_rst_pkg.sv
`timescale 1ns/1ps
package dds_rst_pkg;

    // Which reset source the select input chooses
    typedef enum logic {
        SRC_SW  = 1'b0,
        SRC_PIN = 1'b1
    } rst_src_e;

    localparam int unsigned DEF_CODE_W  = 10;
    localparam int unsigned DEF_LATENCY = 7;

endpackage

// File: rtl/rst_src_mux.sv
`timescale 1ns/1ps
module rst_src_mux
    import dds_rst_pkg::*;
(
    input  logic pin_i,
    input  logic bit_i,
    input  logic sel_i,
    output logic src_o
);
    rst_src_e sel;

    always_comb begin
        sel = rst_src_e'(sel_i);
        unique case (sel)
            SRC_PIN: src_o = pin_i;
            SRC_SW:  src_o = bit_i;
            default: src_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/rst_release_ff.sv
`timescale 1ns/1ps
module rst_release_ff (
    input  logic clk_i,
    input  logic set_i,
    output logic rst_o
);
    typedef struct packed {
        logic held;
    } rel_state_t;

    rel_state_t state_d, state_q;

    // Any sampled edge with the source low is a release
    always_comb begin
        state_d      = state_q;
        state_d.held = 1'b0;
    end

    // Set is asynchronous; release is taken on the falling edge
    always_ff @(negedge clk_i or posedge set_i) begin
        if (set_i) begin
            state_q.held <= 1'b1;
        end else begin
            state_q <= state_d;
        end
    end

    assign rst_o = state_q.held;
endmodule

// File: rtl/restart_timer.sv
`timescale 1ns/1ps
module restart_timer #(
    parameter int unsigned LATENCY = 7
) (
    input  logic clk_i,
    input  logic clr_i,
    input  logic hold_i,
    output logic valid_o
);
    localparam int unsigned CW = (LATENCY < 2) ? 1 : $clog2(LATENCY);
    localparam logic [CW-1:0] LAST = CW'(LATENCY - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          valid;
    } tmr_state_t;

    tmr_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (hold_i) begin
            state_d.cnt   = '0;
            state_d.valid = 1'b0;
        end else if (!state_q.valid) begin
            if (state_q.cnt == LAST) begin
                state_d.valid = 1'b1;
            end else begin
                state_d.cnt = state_q.cnt + CW'(1);
            end
        end
    end

    // A new reset drops the count at once
    always_ff @(negedge clk_i or posedge clr_i) begin
        if (clr_i) begin
            state_q.cnt   <= '0;
            state_q.valid <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end

    assign valid_o = state_q.valid;
endmodule

// File: rtl/code_gate.sv
`timescale 1ns/1ps
module code_gate #(
    parameter int unsigned CODE_W = 10
) (
    input  logic              valid_i,
    input  logic [CODE_W-1:0] code_i,
    output logic [CODE_W-1:0] code_o
);
    localparam logic [CODE_W-1:0] MIDSCALE = {1'b1, {(CODE_W-1){1'b0}}};

    always_comb begin
        code_o = valid_i ? code_i : MIDSCALE;
    end
endmodule

// File: rtl/dds_reset_ctrl.sv
`timescale 1ns/1ps
module dds_reset_ctrl #(
    parameter int unsigned CODE_W  = dds_rst_pkg::DEF_CODE_W,
    parameter int unsigned LATENCY = dds_rst_pkg::DEF_LATENCY
) (
    input  logic              clk_i,
    input  logic              rst_pin_i,
    input  logic              rst_bit_i,
    input  logic              pin_sel_i,
    input  logic [CODE_W-1:0] dp_code_i,
    output logic              dp_rst_o,
    output logic              out_valid_o,
    output logic [CODE_W-1:0] dac_code_o
);
    logic src_active;
    logic rst_held;
    logic valid;

    rst_src_mux u_mux (
        .pin_i (rst_pin_i),
        .bit_i (rst_bit_i),
        .sel_i (pin_sel_i),
        .src_o (src_active)
    );

    rst_release_ff u_rel (
        .clk_i (clk_i),
        .set_i (src_active),
        .rst_o (rst_held)
    );

    restart_timer #(.LATENCY(LATENCY)) u_tmr (
        .clk_i   (clk_i),
        .clr_i   (src_active),
        .hold_i  (rst_held),
        .valid_o (valid)
    );

    code_gate #(.CODE_W(CODE_W)) u_gate (
        .valid_i (valid),
        .code_i  (dp_code_i),
        .code_o  (dac_code_o)
    );

    assign dp_rst_o    = rst_held;
    assign out_valid_o = valid;
endmodule

// File: rtl/dds_reset_ctrl_chk.sv
`timescale 1ns/1ps
module dds_reset_ctrl_chk #(
    parameter int unsigned CODE_W  = 10,
    parameter int unsigned LATENCY = 7
) (
    input logic              clk_i,
    input logic              rst_pin_i,
    input logic              rst_bit_i,
    input logic              pin_sel_i,
    input logic [CODE_W-1:0] dp_code_i,
    input logic              dp_rst_o,
    input logic              out_valid_o,
    input logic [CODE_W-1:0] dac_code_o
);
    localparam int unsigned SW = $clog2(LATENCY + 2);
    localparam logic [CODE_W-1:0] MID = {1'b1, {(CODE_W-1){1'b0}}};

    logic          src;
    logic [SW-1:0] since_rel;

    assign src = pin_sel_i ? rst_pin_i : rst_bit_i;

    // Falling edges seen since the datapath reset dropped
    always_ff @(negedge clk_i) begin
        if (dp_rst_o) begin
            since_rel <= '0;
        end else if (since_rel != SW'(LATENCY + 1)) begin
            since_rel <= since_rel + SW'(1);
        end
    end

    assert_release_next_edge_R4: assert property (@(negedge clk_i) disable iff (src)
        $past(!src) |-> !dp_rst_o);

    assert_valid_on_count_R5: assert property (@(negedge clk_i) disable iff (src)
        $rose(out_valid_o) |-> (since_rel == SW'(LATENCY)));

    assert_no_early_valid_R5: assert property (@(negedge clk_i) disable iff (src)
        (since_rel < SW'(LATENCY)) |-> !out_valid_o);

    assert_midscale_when_idle_R6: assert property (@(negedge clk_i) disable iff (src)
        !out_valid_o |-> (dac_code_o == MID));

    assert_code_passes_R7: assert property (@(negedge clk_i) disable iff (src)
        out_valid_o |-> (dac_code_o == dp_code_i));

    assert_valid_excludes_rst_R8: assert property (@(negedge clk_i) disable iff (src)
        out_valid_o |-> !dp_rst_o);
endmodule

bind dds_reset_ctrl dds_reset_ctrl_chk #(
    .CODE_W  (CODE_W),
    .LATENCY (LATENCY)
) chk_i (
    .clk_i       (clk_i),
    .rst_pin_i   (rst_pin_i),
    .rst_bit_i   (rst_bit_i),
    .pin_sel_i   (pin_sel_i),
    .dp_code_i   (dp_code_i),
    .dp_rst_o    (dp_rst_o),
    .out_valid_o (out_valid_o),
    .dac_code_o  (dac_code_o)
);

// File: tb/dds_reset_ctrl_tb_top.sv
`timescale 1ns/1ps
module dds_reset_ctrl_tb_top;
    localparam int unsigned CODE_W = 10;
    localparam logic [CODE_W-1:0] MID = 10'h200;

    logic              clk = 1'b0;
    logic              rst_pin = 1'b0;
    logic              rst_bit = 1'b0;
    logic              pin_sel = 1'b1;
    logic [CODE_W-1:0] dp_code = '0;
    logic              dp_rst;
    logic              out_valid;
    logic [CODE_W-1:0] dac_code;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    dds_reset_ctrl #(.CODE_W(CODE_W), .LATENCY(7)) dut_i (
        .clk_i       (clk),
        .rst_pin_i   (rst_pin),
        .rst_bit_i   (rst_bit),
        .pin_sel_i   (pin_sel),
        .dp_code_i   (dp_code),
        .dp_rst_o    (dp_rst),
        .out_valid_o (out_valid),
        .dac_code_o  (dac_code)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive_slot();
        @(posedge clk);
        #1;
    endtask

    // Source already low; verify release edge and seven-edge delay
    task automatic expect_release(input string req);
        chk({req, " R4 held before edge"}, 32'(dp_rst), 32'd1);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            #1;
            chk({req, " R4 rst after edge"}, 32'(dp_rst), 32'd0);
            chk({req, " R5 valid count"}, 32'(out_valid), 32'(i == 7));
            if (i < 7) chk({req, " R6 midscale while counting"}, 32'(dac_code), 32'(MID));
        end
    endtask

    task automatic t_reset_state();
        dp_code = 10'h3FF;
        drive_slot();
        chk("R3 reset state rst", 32'(dp_rst), 32'd1);
        chk("R3 reset state valid", 32'(out_valid), 32'd0);
        chk("R6 reset state code", 32'(dac_code), 32'(MID));
    endtask

    task automatic t_pin_release_R1();
        drive_slot();
        rst_pin = 1'b0;
        expect_release("R1 pin");
    endtask

    task automatic t_code_patterns_R7();
        logic [CODE_W-1:0] pats [3] = '{10'h3FF, 10'h000, 10'h155};
        foreach (pats[k]) begin
            drive_slot();
            dp_code = pats[k];
            #0.5;
            chk("R7 passthrough", 32'(dac_code), 32'(pats[k]));
        end
    endtask

    task automatic t_bit_ignored_R1();
        drive_slot();
        rst_bit = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            #1;
            chk("R1 bit ignored rst", 32'(dp_rst), 32'd0);
            chk("R1 bit ignored valid", 32'(out_valid), 32'd1);
        end
        drive_slot();
        rst_bit = 1'b0;
    endtask

    task automatic t_async_pin_R3();
        @(negedge clk);
        #0.5;
        rst_pin = 1'b1;
        #0.5;
        chk("R3 async rst", 32'(dp_rst), 32'd1);
        chk("R3 async valid", 32'(out_valid), 32'd0);
        chk("R3 async code", 32'(dac_code), 32'(MID));
    endtask

    task automatic t_switch_to_sw_R2();
        drive_slot();
        pin_sel = 1'b0;
        rst_bit = 1'b1;
        drive_slot();
        rst_pin = 1'b0;
        drive_slot();
        chk("R2 bit holds reset", 32'(dp_rst), 32'd1);
        rst_bit = 1'b0;
        expect_release("R2 bit");
    endtask

    task automatic t_pin_ignored_R2();
        drive_slot();
        rst_pin = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            #1;
            chk("R2 pin ignored rst", 32'(dp_rst), 32'd0);
            chk("R2 pin ignored valid", 32'(out_valid), 32'd1);
            chk("R2 pin ignored code", 32'(dac_code), 32'(dp_code));
        end
        drive_slot();
        rst_pin = 1'b0;
    endtask

    task automatic t_abort_R8();
        drive_slot();
        rst_bit = 1'b1;
        drive_slot();
        rst_bit = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
        end
        #1;
        chk("R8 mid count valid", 32'(out_valid), 32'd0);
        drive_slot();
        rst_bit = 1'b1;
        #0.5;
        chk("R8 abort rst", 32'(dp_rst), 32'd1);
        for (int i = 0; i < 3; i++) drive_slot();
        rst_bit = 1'b0;
        expect_release("R8 restart");
    endtask

    initial begin
        #1;
        rst_pin = 1'b1;
        t_reset_state();
        t_pin_release_R1();
        t_code_patterns_R7();
        t_bit_ignored_R1();
        t_async_pin_R3();
        t_switch_to_sw_R2();
        t_pin_ignored_R2();
        t_abort_R8();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule